// File: doc/BRIEF.md
# Parallel Video to 7:1 Serial Lane Formatter

This block turns a parallel pixel stream into 7-bit words for up to six serial data lanes per output channel. It shifts each word out at seven times the word rate, most significant bit first. Each channel also gets a forwarded clock lane. That lane repeats a fixed 7-bit pattern in step with the data words. There are two output channels. A mode input chooses between one channel carrying every pixel and two channels that split the stream into even and odd pixels. A 2-bit depth select sets how many lanes carry colour data.

The whole block runs on the bit clock, which is the fast serial clock. A phase counter counts seven bit cycles per word and loads the shift registers once per word, on the load phase. In single-channel mode the pixel inputs are sampled on the load phase. In dual-channel mode two pixels arrive per word period. The even pixel is captured three bit cycles after a load and held. The odd pixel is taken straight from the inputs on the next load, when both channels are loaded together. Depth select and channel mode are sampled on every load.

Top module: `lvds_lane_fmt`

## Requirements
- R1: Bit 6 of lane C (lane index 2) carries data-enable, bit 5 carries vertical sync and bit 4 carries horizontal sync, for the pixel that channel 0 sends.
- R2: Colour bits map to lanes as follows. Lane A word = rgb[6:0] and lane B word = rgb[13:7]. Lane C bits 3..0 = rgb[17:14]. Lanes D, E and F carry rgb[23:18], rgb[29:24] and rgb[35:30] in bits 5..0. Bit 0 of each slice goes to bit 0 of the word.
- R3: With dual_en low, channel 0 carries every pixel. All channel 1 data lanes and its clock lane stay low.
- R4: With dual_en high, the pixel sampled at bit phase 3 goes out on channel 0 and the pixel sampled at the following load goes out on channel 1. Both are in the same word period. Bits 6..4 of channel 1 lane C are driven 0.
- R5: Depth select 00, 01, 10 and 11 enables lanes A–C, A–D, A–E and A–F. Inactive lanes are held low. Bit 6 of lanes D, E and F is always 0.
- R6: Each word is sent bit 6 first and bit 0 last, one bit per bit-clock cycle, so one word period is exactly seven bit cycles. The load phase repeats every seven cycles.
- R7: Each active clock lane outputs 1100011 in every word period, MSB first. Its first bit coincides with bit 6 of the data lanes.
- R8: During reset every output is low and the phase counter sits on the load phase. The first rising edge after reset is released loads the first word, and that word's bit 6 appears right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven cycles per word |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_en | input | 1 | 0: channel 0 only; 1: even/odd split over two channels |
| depth_sel | input | 2 | Colour depth select (lane count) |
| pix_de | input | 1 | Pixel data-enable |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_rgb | input | 36 | Colour bits of the pixel |
| lane_o | output | 12 | Serial data lanes, index = channel*6 + lane (A=0 … F=5) |
| clk_lane_o | output | 2 | Forwarded clock lane per channel |

## Verification
The bench deserializes every lane, using the word boundaries that the clock-lane pattern marks. It checks all eight combinations of channel mode and depth, with random pixels mixed with all-ones and all-zeros words. If the bit order were reversed, or the word shifted by one cycle, every recovered word would be scrambled. If an inactive lane leaked data, a shallow depth would show non-zero words on lanes D–F. Several dual-mode faults are also caught. Swapping even and odd pixels would put the wrong pixel on each channel. Forgetting to clear the control slots on channel 1 would show sync bits there. Loading channel 0 from the live inputs instead of the held pixel would send the odd pixel twice.

// File: rtl/lvfmt_pkg.sv
package lvfmt_pkg;
    localparam int WORD_W     = 7;
    localparam int N_LANES    = 6;
    localparam int N_CH       = 2;
    localparam int DEPTH_W    = 2;
    localparam int FULL_LANES = 2;
    localparam int CTL_LANE   = 2;
    localparam int BASE_LANES = 3;
    localparam int CTL_BITS   = 3;
    localparam int CTL_DATA   = WORD_W - CTL_BITS;
    localparam int EXT_DATA   = WORD_W - 1;
    localparam int PIX_W      = FULL_LANES * WORD_W + CTL_DATA
                              + (N_LANES - BASE_LANES) * EXT_DATA;
    localparam int CAP_PH     = WORD_W / 2;
    localparam logic [WORD_W-1:0] CLK_PAT = 7'b1100011;

    typedef logic [N_LANES-1:0][WORD_W-1:0] lanes_t;

    typedef struct packed {
        logic             de;
        logic             vs;
        logic             hs;
        logic [PIX_W-1:0] rgb;
    } pixel_t;
endpackage

// File: rtl/lvfmt_phase.sv
module lvfmt_phase #(
    parameter int WORD_W = 7,
    parameter int CAP_PH = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic cap_o
);
    localparam int PH_W = $clog2(WORD_W);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.ph == PH_W'(WORD_W - 1)) s_d.ph = '0;
        else                             s_d.ph = s_q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign load_o = (s_q.ph == '0);
    assign cap_o  = (s_q.ph == PH_W'(CAP_PH));

    // R6
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_W'(WORD_W - 1)) |=> load_o);

    // R6
    load_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
endmodule

// File: rtl/lvfmt_mapper.sv
module lvfmt_mapper
    import lvfmt_pkg::*;
(
    input  pixel_t               pix_i,
    input  logic [DEPTH_W-1:0]   depth_i,
    input  logic                 strip_i,
    output lanes_t               lanes_o
);
    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        if (l < FULL_LANES) begin : g_full
            assign lanes_o[l] = pix_i.rgb[l*WORD_W +: WORD_W];
        end else if (l == CTL_LANE) begin : g_ctl
            logic [CTL_BITS-1:0] ctl;
            assign ctl = strip_i ? '0 : {pix_i.de, pix_i.vs, pix_i.hs};
            assign lanes_o[l] = {ctl, pix_i.rgb[FULL_LANES*WORD_W +: CTL_DATA]};
        end else begin : g_ext
            localparam int OFS = FULL_LANES*WORD_W + CTL_DATA
                               + (l - CTL_LANE - 1) * EXT_DATA;
            logic act;
            assign act = (int'(depth_i) + BASE_LANES) > l;
            assign lanes_o[l] = act ? {1'b0, pix_i.rgb[OFS +: EXT_DATA]} : '0;
        end
    end
endmodule

// File: rtl/lvfmt_ser.sv
module lvfmt_ser #(
    parameter int                N_LANES = 6,
    parameter int                WORD_W  = 7,
    parameter logic [WORD_W-1:0] CLK_PAT = 7'b1100011
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load_i,
    input  logic                             en_i,
    input  logic [N_LANES-1:0][WORD_W-1:0]   word_i,
    output logic [N_LANES-1:0]               lane_o,
    output logic                             clk_o
);
    typedef struct packed {
        logic [N_LANES-1:0][WORD_W-1:0] sr;
        logic [WORD_W-1:0]              ck;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.sr = en_i ? word_i  : '0;
            s_d.ck = en_i ? CLK_PAT : '0;
        end else begin
            for (int l = 0; l < N_LANES; l++) begin
                s_d.sr[l] = {s_q.sr[l][WORD_W-2:0], 1'b0};
            end
            s_d.ck = {s_q.ck[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [N_LANES-1:0] nxt_bits;
    for (genvar l = 0; l < N_LANES; l++) begin : g_out
        assign lane_o[l]   = s_q.sr[l][WORD_W-1];
        assign nxt_bits[l] = s_q.sr[l][WORD_W-2];
    end
    assign clk_o = s_q.ck[WORD_W-1];

    // R6
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (lane_o == $past(nxt_bits)));

    // R7
    clk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && en_i) |=> (clk_o == CLK_PAT[WORD_W-1]));
endmodule

// File: rtl/lvds_lane_fmt.sv
module lvds_lane_fmt
    import lvfmt_pkg::*;
(
    input  logic                      clk_bit,
    input  logic                      rst_n,
    input  logic                      dual_en,
    input  logic [DEPTH_W-1:0]        depth_sel,
    input  logic                      pix_de,
    input  logic                      pix_hs,
    input  logic                      pix_vs,
    input  logic [PIX_W-1:0]          pix_rgb,
    output logic [N_CH*N_LANES-1:0]   lane_o,
    output logic [N_CH-1:0]           clk_lane_o
);
    typedef struct packed {
        pixel_t hold;
    } st_t;

    st_t    s_d, s_q;
    pixel_t live;
    logic   load, cap;

    assign live = '{de: pix_de, vs: pix_vs, hs: pix_hs, rgb: pix_rgb};

    lvfmt_phase #(.WORD_W(WORD_W), .CAP_PH(CAP_PH)) phase_i (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .load_o (load),
        .cap_o  (cap)
    );

    always_comb begin
        s_d = s_q;
        if (cap && dual_en) s_d.hold = live;
    end

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pixel_t src;
        lanes_t words;
        logic   strip, en;

        if (c == 0) begin : g_first
            assign src   = dual_en ? s_q.hold : live;
            assign strip = 1'b0;
            assign en    = 1'b1;
        end else begin : g_other
            assign src   = live;
            assign strip = 1'b1;
            assign en    = dual_en;
        end

        lvfmt_mapper map_i (
            .pix_i   (src),
            .depth_i (depth_sel),
            .strip_i (strip),
            .lanes_o (words)
        );

        lvfmt_ser #(.N_LANES(N_LANES), .WORD_W(WORD_W), .CLK_PAT(CLK_PAT)) ser_i (
            .clk    (clk_bit),
            .rst_n  (rst_n),
            .load_i (load),
            .en_i   (en),
            .word_i (words),
            .lane_o (lane_o[c*N_LANES +: N_LANES]),
            .clk_o  (clk_lane_o[c])
        );
    end

    // R3
    single_idle_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (load && !dual_en) |=> ((lane_o[N_LANES +: N_LANES] == '0) && !clk_lane_o[1]));

    // R4
    dual_ctl_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (load && dual_en) |=> !lane_o[N_LANES + CTL_LANE]);

    // R5
    idle_lane_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (load && depth_sel == '0) |=> (lane_o[N_LANES-1:BASE_LANES] == '0));

    // R1
    de_slot_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (load && !dual_en) |=> (lane_o[CTL_LANE] == $past(pix_de)));
endmodule

// File: tb/lvds_lane_fmt_tb_top.sv
module lvds_lane_fmt_tb_top;
    import lvfmt_pkg::*;

    logic                    clk_bit = 1'b0;
    logic                    rst_n   = 1'b0;
    logic                    dual_en = 1'b0;
    logic [1:0]              depth_sel = '0;
    logic                    pix_de = 1'b0, pix_hs = 1'b0, pix_vs = 1'b0;
    logic [PIX_W-1:0]        pix_rgb = '0;
    logic [N_CH*N_LANES-1:0] lane_o;
    logic [N_CH-1:0]         clk_lane_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk_bit = ~clk_bit;

    lvds_lane_fmt dut_i (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .dual_en    (dual_en),
        .depth_sel  (depth_sel),
        .pix_de     (pix_de),
        .pix_hs     (pix_hs),
        .pix_vs     (pix_vs),
        .pix_rgb    (pix_rgb),
        .lane_o     (lane_o),
        .clk_lane_o (clk_lane_o)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected lane words from R1, R2, R4 and R5
    function automatic lanes_t exp_lanes(input pixel_t p, input logic [1:0] depth, input logic strip);
        lanes_t e = '0;
        e[0] = p.rgb[6:0];
        e[1] = p.rgb[13:7];
        e[2] = {(strip ? 3'b000 : {p.de, p.vs, p.hs}), p.rgb[17:14]};
        if (depth >= 2'd1) e[3] = {1'b0, p.rgb[23:18]};
        if (depth >= 2'd2) e[4] = {1'b0, p.rgb[29:24]};
        if (depth == 2'd3) e[5] = {1'b0, p.rgb[35:30]};
        return e;
    endfunction

    function automatic pixel_t gen_pix(input int idx);
        pixel_t p;
        if (idx == 1)      p = '1;
        else if (idx == 2) p = '{de: 1'b1, vs: 1'b0, hs: 1'b0, rgb: '0};
        else begin
            p.rgb = PIX_W'({$urandom, $urandom});
            p.de  = 1'($urandom);
            p.vs  = 1'($urandom);
            p.hs  = 1'($urandom);
        end
        return p;
    endfunction

    task automatic drive(input pixel_t p);
        pix_de  = p.de;
        pix_vs  = p.vs;
        pix_hs  = p.hs;
        pix_rgb = p.rgb;
    endtask

    task automatic run_seg(input logic dual, input logic [1:0] depth, input int nw);
        pixel_t q0 [0:63];
        pixel_t q1 [0:63];
        lanes_t rx0, rx1;
        logic [WORD_W-1:0] ck0, ck1;
        rx0 = '0; rx1 = '0; ck0 = '0; ck1 = '0;
        for (int i = 0; i < 64; i++) begin q0[i] = '0; q1[i] = '0; end

        @(negedge clk_bit);
        rst_n     = 1'b0;
        dual_en   = dual;
        depth_sel = depth;
        drive(gen_pix(5));
        repeat (2) @(negedge clk_bit);
        // R8: outputs low during reset
        chk({lane_o, clk_lane_o} == '0, "R8 reset outputs", 64'({lane_o, clk_lane_o}), 64'd0);
        rst_n = 1'b1;

        for (int n = 0; n < WORD_W * (nw + 1); n++) begin
            int b, m;
            b = n % WORD_W;
            m = n / WORD_W;
            if (!dual) begin
                if (b == 0) begin
                    q0[m] = gen_pix(m);
                    drive(q0[m]);
                end
            end else begin
                if (b == CAP_PH) begin
                    q0[m] = gen_pix(2 * m);
                    drive(q0[m]);
                end else if (b == 0 && n > 0) begin
                    q1[m-1] = gen_pix(2 * m + 1);
                    drive(q1[m-1]);
                end
            end
            @(posedge clk_bit);
            @(negedge clk_bit);
            for (int l = 0; l < N_LANES; l++) begin
                rx0[l][WORD_W-1-b] = lane_o[l];
                rx1[l][WORD_W-1-b] = lane_o[N_LANES + l];
            end
            ck0[WORD_W-1-b] = clk_lane_o[0];
            ck1[WORD_W-1-b] = clk_lane_o[1];

            if (b == WORD_W - 1) begin
                if (!dual && m < nw) begin
                    lanes_t e0;
                    e0 = exp_lanes(q0[m], depth, 1'b0);
                    // R2 R5 R6: whole recovered word set
                    chk(rx0 == e0, "R2/R5/R6 ch0 lanes", 64'(rx0), 64'(e0));
                    // R1: control slots
                    chk(rx0[2][6:4] == {q0[m].de, q0[m].vs, q0[m].hs}, "R1 ctl slots",
                        64'(rx0[2][6:4]), 64'({q0[m].de, q0[m].vs, q0[m].hs}));
                    // R3: channel 1 idle
                    chk(rx1 == '0 && ck1 == '0, "R3 ch1 idle", 64'({rx1, ck1}), 64'd0);
                    // R7
                    chk(ck0 == 7'b1100011, "R7 clk lane ch0", 64'(ck0), 64'(7'b1100011));
                end else if (dual && m >= 1 && m <= nw) begin
                    lanes_t e0, e1;
                    e0 = exp_lanes(q0[m-1], depth, 1'b0);
                    e1 = exp_lanes(q1[m-1], depth, 1'b1);
                    // R4: even pixel on ch0, odd pixel on ch1 with cleared ctl
                    chk(rx0 == e0, "R4 ch0 even", 64'(rx0), 64'(e0));
                    chk(rx1 == e1, "R4 ch1 odd", 64'(rx1), 64'(e1));
                    // R7
                    chk(ck0 == 7'b1100011 && ck1 == 7'b1100011, "R7 clk lanes dual",
                        64'({ck0, ck1}), 64'({7'b1100011, 7'b1100011}));
                end
                rx0 = '0; rx1 = '0; ck0 = '0; ck1 = '0;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 4; k++) begin
                run_seg(1'(d), 2'(k), 20);
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_bit);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule